// File: doc/BRIEF.md
# E3 Frame Alignment Maintenance Unit

This block sits behind the pattern matcher of an E3 receive framer. At each frame start, the matcher reports whether the frame alignment word appeared where it was expected. From that one-bit result per frame, the block runs the alignment state machine. It holds the receiver in one of three states: pattern search (`ST_SEARCH`), locked maintenance (`ST_INFRAME`) or alignment lost (`ST_OOF`). It also derives a slower loss-of-frame alarm, whose persistence threshold software selects.

The block counts every errored alignment word seen while locked. The count is kept in a saturating 16-bit event counter. A host reads it as two byte registers: reading the upper byte captures the lower byte into a shadow register, so the pair is read coherently, and it clears the live count. A host write can force a fresh search at any moment.

The state transitions are as follows:
- Search to in-frame (lock): after `LOCK_FRAMES` consecutive valid words.
- In-frame to out-of-frame (loss): after `OOF_ERRS` consecutive errored words.
- Out-of-frame to search (restart): on the next frame strobe.
- Any state to search (reframe): on a software reframe command.

Host registers, by byte address:
- Address 0 is status. Bit 0 is the loss-of-frame threshold select and is read/write. Bit 1 is the out-of-frame flag and bit 2 is the loss-of-frame flag; both are read-only. All other bits read 0.
- Address 1 is control. Writing 1 to bit 0 requests a reframe. The register reads 0.
- Address 2 is the upper byte of the error count.
- Address 3 is the lower byte (the shadow).

Top module: `e3fa_maint`

## Requirements
- R1: After reset the state is search, `oof_o` is 1, `lof_o` is 0, the error count and its shadow are 0, and the threshold select bit is 0. The status register then reads 0x02.
- R2: In search, `LOCK_FRAMES` consecutive frame strobes with `fas_ok`=1 enter in-frame, and `oof_o` falls in the cycle after the last of them. A strobe with `fas_ok`=0 restarts the run.
- R3: In-frame, up to `OOF_ERRS`-1 consecutive errored frames leave the state in-frame. A valid frame restarts the error run.
- R4: The `OOF_ERRS`-th consecutive errored frame enters out-of-frame, and `oof_o` rises in the next cycle. The next strobe moves to search, and that frame already counts as the first search candidate.
- R5: Every errored frame seen while in-frame adds one to the error count, including the one that causes the loss. Errored frames in search or out-of-frame add nothing.
- R6: The error count saturates at 0xFFFF and does not wrap.
- R7: A read of address 2 returns the upper byte one cycle later, latches the lower byte into the shadow and clears the count. An increment in that same cycle is kept, so the count becomes 1. A read of address 3 returns the shadow one cycle later and then clears the shadow.
- R8: Writing 1 to bit 0 of address 1 forces search from any state and discards any lock progress. A frame strobe in the same cycle is ignored for both alignment and counting.
- R9: Frame strobes that arrive while not in-frame are counted toward loss of frame. `lof_o` is 1 once that count reaches `LOF_SHORT` (select bit 0) or `LOF_LONG` (select bit 1). The count clears when in-frame is entered.
- R10: Writes to status bits 1 and 2 have no effect. Only bit 0 is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle pulse at each frame's alignment check |
| fas_ok | input | 1 | Alignment word valid for this frame (qualified by frame_stb) |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data, valid the cycle after host_rd |
| oof_o | output | 1 | Out-of-frame flag (state is not in-frame) |
| lof_o | output | 1 | Loss-of-frame alarm |

## Verification
The bench builds the block with `LOCK_FRAMES`=3 and `OOF_ERRS`=4, plus short loss-of-frame thresholds (`LOF_SHORT`=2, `LOF_LONG`=5). These settings let both alarm thresholds and the switch between them show up within a handful of frames. Because the counter stays 16 bits wide, saturation requires more than 65535 errored frames. The bench reaches it by repeating three errors and one good frame, which keeps the receiver locked throughout. The run also covers three other cases: a read that collides with an increment, a reframe that collides with a frame strobe, and the frame seen in out-of-frame counting toward the new lock.

// File: rtl/e3fa_pkg.sv
package e3fa_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_INFRAME = 2'd1,
        ST_OOF     = 2'd2
    } align_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/e3fa_align_fsm.sv
module e3fa_align_fsm
    import e3fa_pkg::*;
#(
    parameter int LOCK_FRAMES = 3,
    parameter int OOF_ERRS    = 4,
    parameter int LOF_SHORT   = 8,
    parameter int LOF_LONG    = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_stb,
    input  logic         fas_ok,
    input  logic         reframe,
    input  logic         lof_algo,
    output align_state_t state_o,
    output logic         err_event,
    output logic         oof,
    output logic         lof
);

    localparam int LOF_MAX = (LOF_SHORT > LOF_LONG) ? LOF_SHORT : LOF_LONG;
    localparam int GOOD_W  = $clog2(LOCK_FRAMES + 1);
    localparam int BAD_W   = $clog2(OOF_ERRS + 1);
    localparam int LOF_W   = $clog2(LOF_MAX + 1);

    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_FRAMES - 1);
    localparam logic [BAD_W-1:0]  BAD_LAST  = BAD_W'(OOF_ERRS - 1);
    localparam logic [LOF_W-1:0]  LOF_TOP   = LOF_W'(LOF_MAX);
    localparam logic [LOF_W-1:0]  THR_SHORT = LOF_W'(LOF_SHORT);
    localparam logic [LOF_W-1:0]  THR_LONG  = LOF_W'(LOF_LONG);

    align_state_t      state_q, state_d;
    logic [GOOD_W-1:0] good_q, good_d;
    logic [BAD_W-1:0]  bad_q, bad_d;
    logic [LOF_W-1:0]  lof_q, lof_d;
    logic              frame_live;

    assign frame_live = frame_stb && !reframe;

    // next-state and run counters
    always_comb begin
        state_d = state_q;
        good_d  = good_q;
        bad_d   = bad_q;
        if (reframe) begin
            state_d = ST_SEARCH;
            good_d  = '0;
            bad_d   = '0;
        end else if (frame_stb) begin
            unique case (state_q)
                ST_SEARCH, ST_OOF: begin
                    bad_d = '0;
                    if (fas_ok) begin
                        if (good_q == GOOD_LAST) begin
                            state_d = ST_INFRAME;
                            good_d  = '0;
                        end else begin
                            state_d = ST_SEARCH;
                            good_d  = good_q + 1'b1;
                        end
                    end else begin
                        state_d = ST_SEARCH;
                        good_d  = '0;
                    end
                end
                ST_INFRAME: begin
                    good_d = '0;
                    if (fas_ok) begin
                        bad_d = '0;
                    end else if (bad_q == BAD_LAST) begin
                        state_d = ST_OOF;
                        bad_d   = '0;
                    end else begin
                        bad_d = bad_q + 1'b1;
                    end
                end
                default: begin
                    state_d = ST_SEARCH;
                    good_d  = '0;
                    bad_d   = '0;
                end
            endcase
        end
    end

    // loss-of-frame persistence counter
    always_comb begin
        lof_d = lof_q;
        if (state_d == ST_INFRAME) begin
            lof_d = '0;
        end else if (frame_live && state_q != ST_INFRAME && lof_q != LOF_TOP) begin
            lof_d = lof_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
            good_q  <= '0;
            bad_q   <= '0;
            lof_q   <= '0;
        end else begin
            state_q <= state_d;
            good_q  <= good_d;
            bad_q   <= bad_d;
            lof_q   <= lof_d;
        end
    end

    // outputs
    always_comb begin
        state_o   = state_q;
        oof       = (state_q != ST_INFRAME);
        err_event = frame_live && !fas_ok && (state_q == ST_INFRAME);
        lof       = (lof_q >= (lof_algo ? THR_LONG : THR_SHORT));
    end

endmodule

// File: rtl/e3fa_err_counter.sv
module e3fa_err_counter
    import e3fa_pkg::*;
#(
    parameter int HALF_W = BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc,
    input  logic                rd_hi,
    input  logic                rd_lo,
    output logic [2*HALF_W-1:0] cnt_o,
    output logic [HALF_W-1:0]   shadow_o
);

    localparam int CNT_W = 2 * HALF_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0]  cnt_q;
    logic [HALF_W-1:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rd_hi) begin
            cnt_q <= inc ? CNT_ONE : '0;
        end else if (inc && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (rd_hi) begin
            shadow_q <= cnt_q[HALF_W-1:0];
        end else if (rd_lo) begin
            shadow_q <= '0;
        end
    end

    assign cnt_o    = cnt_q;
    assign shadow_o = shadow_q;

endmodule

// File: rtl/e3fa_host_regs.sv
module e3fa_host_regs
    import e3fa_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_rd,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [BYTE_W-1:0]   host_wdata,
    input  logic                oof,
    input  logic                lof,
    input  logic [2*BYTE_W-1:0] cnt,
    input  logic [BYTE_W-1:0]   shadow,
    output logic [BYTE_W-1:0]   host_rdata,
    output logic                lof_algo,
    output logic                reframe,
    output logic                rd_hi,
    output logic                rd_lo
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_ERR_HI = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_ERR_LO = ADDR_W'(3);

    logic              algo_q;
    logic [BYTE_W-1:0] rd_mux;

    always_comb begin
        reframe = host_wr && (host_addr == A_CTRL) && host_wdata[0];
        rd_hi   = host_rd && (host_addr == A_ERR_HI);
        rd_lo   = host_rd && (host_addr == A_ERR_LO);
    end

    always_comb begin
        rd_mux = '0;
        unique case (host_addr)
            A_STATUS: rd_mux = {{(BYTE_W-3){1'b0}}, lof, oof, algo_q};
            A_ERR_HI: rd_mux = cnt[2*BYTE_W-1:BYTE_W];
            A_ERR_LO: rd_mux = shadow;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            algo_q <= 1'b0;
        end else if (host_wr && host_addr == A_STATUS) begin
            algo_q <= host_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            host_rdata <= rd_mux;
        end
    end

    assign lof_algo = algo_q;

endmodule

// File: rtl/e3fa_maint.sv
module e3fa_maint
    import e3fa_pkg::*;
#(
    parameter int LOCK_FRAMES = 3,
    parameter int OOF_ERRS    = 4,
    parameter int LOF_SHORT   = 8,
    parameter int LOF_LONG    = 24,
    parameter int ADDR_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              fas_ok,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              oof_o,
    output logic              lof_o
);

    align_state_t          align_state;
    logic                  err_event;
    logic                  reframe_req;
    logic                  lof_algo;
    logic                  rd_hi;
    logic                  rd_lo;
    logic [2*BYTE_W-1:0]   err_cnt;
    logic [BYTE_W-1:0]     err_shadow;

    e3fa_align_fsm #(
        .LOCK_FRAMES (LOCK_FRAMES),
        .OOF_ERRS    (OOF_ERRS),
        .LOF_SHORT   (LOF_SHORT),
        .LOF_LONG    (LOF_LONG)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .fas_ok    (fas_ok),
        .reframe   (reframe_req),
        .lof_algo  (lof_algo),
        .state_o   (align_state),
        .err_event (err_event),
        .oof       (oof_o),
        .lof       (lof_o)
    );

    e3fa_err_counter #(
        .HALF_W (BYTE_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (err_event),
        .rd_hi    (rd_hi),
        .rd_lo    (rd_lo),
        .cnt_o    (err_cnt),
        .shadow_o (err_shadow)
    );

    e3fa_host_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .oof        (oof_o),
        .lof        (lof_o),
        .cnt        (err_cnt),
        .shadow     (err_shadow),
        .host_rdata (host_rdata),
        .lof_algo   (lof_algo),
        .reframe    (reframe_req),
        .rd_hi      (rd_hi),
        .rd_lo      (rd_lo)
    );

endmodule

// File: rtl/e3fa_maint_chk.sv
module e3fa_maint_chk
    import e3fa_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input align_state_t state,
    input logic         reframe,
    input logic         err_event,
    input logic         rd_hi,
    input logic [15:0]  err_cnt,
    input logic         frame_stb,
    input logic         fas_ok,
    input logic         oof,
    input logic         lof
);

    assert_reframe_search_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reframe |=> (state == ST_SEARCH));

    assert_good_keeps_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INFRAME && frame_stb && fas_ok && !reframe) |=> (state == ST_INFRAME));

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == 16'hFFFF && !rd_hi) |=> (err_cnt == 16'hFFFF));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_event && !rd_hi && err_cnt != 16'hFFFF) |=> (err_cnt == $past(err_cnt) + 16'd1));

    assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && !err_event) |=> (err_cnt == 16'd0));

    assert_lof_implies_oof_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lof |-> oof);

    assert_oof_leaves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OOF && frame_stb) |=> (state == ST_SEARCH));

endmodule

bind e3fa_maint e3fa_maint_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (align_state),
    .reframe   (reframe_req),
    .err_event (err_event),
    .rd_hi     (rd_hi),
    .err_cnt   (err_cnt),
    .frame_stb (frame_stb),
    .fas_ok    (fas_ok),
    .oof       (oof_o),
    .lof       (lof_o)
);

// File: tb/e3fa_maint_bench.sv
`timescale 1ns/1ps
module e3fa_maint_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       fas_ok = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       oof_o;
    logic       lof_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic rd_pend = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    e3fa_maint #(
        .LOCK_FRAMES (3),
        .OOF_ERRS    (4),
        .LOF_SHORT   (2),
        .LOF_LONG    (5),
        .ADDR_W      (2)
    ) u_e3fa_maint (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .fas_ok     (fas_ok),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .oof_o      (oof_o),
        .lof_o      (lof_o)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic chk_flags(string tag, logic e_oof, logic e_lof);
        chk({tag, " oof"}, {7'd0, oof_o}, {7'd0, e_oof});
        chk({tag, " lof"}, {7'd0, lof_o}, {7'd0, e_lof});
    endtask

    task automatic frame(logic ok);
        @(negedge clk);
        frame_stb = 1'b1;
        fas_ok    = ok;
        @(posedge clk);
        #1;
        frame_stb = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] expv, string tag);
        @(negedge clk);
        host_rd   = 1'b1;
        host_addr = a;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        host_rd = 1'b0;
    endtask

    task automatic rd_frame(logic [1:0] a, logic [7:0] expv, logic ok, string tag);
        @(negedge clk);
        host_rd   = 1'b1;
        host_addr = a;
        frame_stb = 1'b1;
        fas_ok    = ok;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        host_rd   = 1'b0;
        frame_stb = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, logic with_frame, logic ok);
        @(negedge clk);
        host_wr    = 1'b1;
        host_addr  = a;
        host_wdata = d;
        frame_stb  = with_frame;
        fas_ok     = ok;
        @(posedge clk);
        #1;
        host_wr   = 1'b0;
        frame_stb = 1'b0;
    endtask

    // scoreboard monitor: read data is valid the cycle after the strobe
    always @(posedge clk) rd_pend <= host_rd;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL scoreboard empty actual=%h expected=none", host_rdata);
            end else begin
                chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk_flags("R1 reset", 1'b1, 1'b0);
        rd(2'd0, 8'h02, "R1 R10 status after reset");
        rd(2'd2, 8'h00, "R1 err hi after reset");
        rd(2'd3, 8'h00, "R1 err lo after reset");

        // R2 lock, R9 short threshold
        frame(1'b1);
        chk_flags("R9 one search frame", 1'b1, 1'b0);
        frame(1'b0);
        chk_flags("R9 short threshold", 1'b1, 1'b1);
        frame(1'b1);
        frame(1'b1);
        chk_flags("R2 run restarted by bad frame", 1'b1, 1'b1);
        frame(1'b1);
        chk_flags("R2 R9 locked", 1'b0, 1'b0);

        // R3 tolerate three errors, R5 counted, R7 read
        frame(1'b0); frame(1'b0); frame(1'b0);
        chk_flags("R3 three errors keep lock", 1'b0, 1'b0);
        frame(1'b1);
        rd(2'd2, 8'h00, "R7 hi of three");
        rd(2'd3, 8'h03, "R5 R7 lo of three");
        rd(2'd3, 8'h00, "R7 shadow cleared by lo read");
        rd(2'd2, 8'h00, "R7 count cleared by hi read");

        // R4 loss on fourth, R5 no count outside lock
        frame(1'b0); frame(1'b0); frame(1'b0);
        chk_flags("R3 still locked", 1'b0, 1'b0);
        frame(1'b0);
        chk_flags("R4 fourth error", 1'b1, 1'b0);
        rd(2'd0, 8'h02, "R4 status oof");
        frame(1'b0);
        frame(1'b0);
        chk_flags("R9 lof during search", 1'b1, 1'b1);
        frame(1'b1); frame(1'b1);
        chk_flags("R2 not yet locked", 1'b1, 1'b1);
        frame(1'b1);
        chk_flags("R2 relocked", 1'b0, 1'b0);
        rd(2'd2, 8'h00, "R5 hi");
        rd(2'd3, 8'h04, "R5 search errors not counted");

        // R10 only bit 0 stored, R8 reframe, R9 long threshold
        wr(2'd0, 8'hFF, 1'b0, 1'b0);
        rd(2'd0, 8'h01, "R10 status after write of ff");
        wr(2'd1, 8'h01, 1'b0, 1'b0);
        chk_flags("R8 reframe forces search", 1'b1, 1'b0);
        frame(1'b1); frame(1'b1);
        chk_flags("R9 long threshold not reached", 1'b1, 1'b0);
        frame(1'b0); frame(1'b0); frame(1'b0);
        chk_flags("R9 long threshold reached", 1'b1, 1'b1);
        rd(2'd0, 8'h07, "R9 R10 status all set");
        frame(1'b1); frame(1'b1); frame(1'b1);
        chk_flags("R2 lock after long search", 1'b0, 1'b0);
        wr(2'd0, 8'h00, 1'b0, 1'b0);
        rd(2'd0, 8'h00, "R10 select cleared");

        // R4 out-of-frame frame is first search candidate
        frame(1'b0); frame(1'b0); frame(1'b0); frame(1'b0);
        chk_flags("R4 loss again", 1'b1, 1'b0);
        frame(1'b1); frame(1'b1);
        chk_flags("R4 two candidates", 1'b1, 1'b1);
        frame(1'b1);
        chk_flags("R4 oof frame counted toward lock", 1'b0, 1'b0);

        // R8 reframe beats a simultaneous frame
        wr(2'd1, 8'h01, 1'b1, 1'b0);
        chk_flags("R8 reframe with frame", 1'b1, 1'b0);
        frame(1'b1); frame(1'b1);
        chk_flags("R8 simultaneous frame ignored", 1'b1, 1'b1);
        frame(1'b1);
        chk_flags("R8 relock", 1'b0, 1'b0);
        rd(2'd2, 8'h00, "R8 hi");
        rd(2'd3, 8'h04, "R8 simultaneous bad frame not counted");

        // R7 read colliding with increment
        frame(1'b0);
        rd_frame(2'd2, 8'h00, 1'b0, "R7 hi during increment");
        rd(2'd3, 8'h01, "R7 shadow of one");
        frame(1'b1);
        rd(2'd2, 8'h00, "R7 hi after collision");
        rd(2'd3, 8'h01, "R7 increment kept");

        // R6 saturation
        for (int i = 0; i < 21846; i++) begin
            frame(1'b0); frame(1'b0); frame(1'b0); frame(1'b1);
        end
        chk_flags("R6 lock held through error bursts", 1'b0, 1'b0);
        rd(2'd2, 8'hFF, "R6 hi saturated");
        rd(2'd3, 8'hFF, "R6 lo saturated");
        rd(2'd2, 8'h00, "R6 cleared hi");
        rd(2'd3, 8'h00, "R6 cleared lo");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule